// File: doc/BRIEF.md
# Processor Context Table Loader

This block restores the complete register context of a 16-bit segmented processor model from a fixed table in memory. When its trigger is pulsed while idle, it walks a 51-word table at a hard-wired base address one word at a time. It waits for the memory to acknowledge each read before asking for the next one. Each word is sorted into a shadow copy of the context. Words that belong to no register are fetched like any other word and then dropped.

The table covers the general registers, the segment selectors, the flags, the instruction pointer, the machine status word, the task and local-table selectors, four segment descriptor caches, and the global, interrupt, local-table and task-state table registers. Once the last word has arrived, a single commit pulse moves the whole shadow onto the outputs at the same edge. The outputs also include the resulting instruction fetch address, which comes from the code segment cache base and the instruction pointer.

Every descriptor-style entry takes three consecutive words. The first word holds base bits 15:0. The second word holds base bits 23:16 in its low byte and an access byte in its high byte. The third word holds the limit.

Top module: `ctx_table_loader`

## Requirements
- R1: While reset is held, and after it is released, every register output, `fetch_addr_o`, `busy_o`, `commit_o`, `done_o` and `mem_req_o` is zero.
- R2: A trigger while idle starts reads at byte address 0x000800, then steps by 2 up to 0x000864, 51 words in total. Each address is held with `mem_req_o` high until a cycle in which `mem_ready_i` is high, and `mem_rdata_i` is taken in that cycle.
- R3: A trigger that arrives while `busy_o` is high has no effect on the read sequence or on the outputs.
- R4: No register output changes before the load completes. `commit_o` is high for exactly the one cycle after the last word is accepted. In the following cycle all outputs show the new values, `busy_o` falls, and `done_o` rises. `done_o` stays high until the next accepted trigger.
- R5: Single-word slots are taken from these byte addresses: task selector 0x816, flags 0x818, instruction pointer 0x81A, local-table selector 0x81C. The segment selectors come from 0x81E (DS), 0x820 (SS), 0x822 (CS) and 0x824 (ES). `seg_sel_o` index 0..3 means ES, CS, SS, DS.
- R6: `gpr_o` index 0..7 is DI, SI, BP, SP, BX, DX, CX, AX, loaded from 0x826 up to 0x834 in steps of 2.
- R7: The segment caches `seg_*_o` with index 0..3 (ES, CS, SS, DS) start at 0x836, 0x83C, 0x842 and 0x848. The local-table cache starts at 0x854 and the task-state cache at 0x860. Each entry uses the three-word format (base low, then {access, base high}, then limit).
- R8: The global table register starts at 0x84E and the interrupt table register at 0x85A. For both, the high byte of the middle word has no effect on any output.
- R9: `msw_o` takes bits 3:0 of the word at 0x806. Bits 15:4 of that word have no effect.
- R10: `fetch_addr_o` equals the CS cache base plus the instruction pointer, modulo 2^24. The CS selector does not take part.
- R11: The words at 0x800–0x805 and 0x808–0x815 are read but have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load trigger, honoured only while idle |
| mem_req_o | output | 1 | Read request, held until acknowledged |
| mem_addr_o | output | ADDR_W | Byte address of the word being read |
| mem_rdata_i | input | 16 | Read data, valid while `mem_ready_i` is high |
| mem_ready_i | input | 1 | Read acknowledge |
| busy_o | output | 1 | Load in progress, including the commit cycle |
| commit_o | output | 1 | One-cycle strobe; outputs update at its end |
| done_o | output | 1 | High from commit until the next accepted trigger |
| msw_o | output | 4 | Machine status bits |
| task_sel_o | output | 16 | Task selector |
| flags_o | output | 16 | Flags word |
| ip_o | output | 16 | Instruction pointer |
| ldt_sel_o | output | 16 | Local-table selector |
| seg_sel_o | output | 4x16 | Segment selectors ES, CS, SS, DS |
| gpr_o | output | 8x16 | General registers DI, SI, BP, SP, BX, DX, CX, AX |
| seg_base_o | output | 4x24 | Segment cache bases |
| seg_acc_o | output | 4x8 | Segment cache access bytes |
| seg_lim_o | output | 4x16 | Segment cache limits |
| gdt_base_o | output | 24 | Global table base |
| gdt_lim_o | output | 16 | Global table limit |
| idt_base_o | output | 24 | Interrupt table base |
| idt_lim_o | output | 16 | Interrupt table limit |
| ldtc_base_o | output | 24 | Local-table cache base |
| ldtc_acc_o | output | 8 | Local-table cache access byte |
| ldtc_lim_o | output | 16 | Local-table cache limit |
| tssc_base_o | output | 24 | Task-state cache base |
| tssc_acc_o | output | 8 | Task-state cache access byte |
| tssc_lim_o | output | 16 | Task-state cache limit |
| fetch_addr_o | output | 24 | CS cache base plus instruction pointer |

## Verification
The bench builds the block with its defaults: a 24-bit bus and the table at 0x000800. This puts the whole table inside a 51-word bench memory. It also lets a code segment base near 0xFFFFFF wrap the fetch address past the top of the address space. The memory acknowledges either at once or after pseudo-random stalls, so address holding, extra triggers during a load, and the exact commit cycle are all exercised. The bench also repeats a table that differs only in its dead words, the status word's upper bits and the table registers' spare bytes, to show that these bytes never reach an output.

// File: rtl/ldr_pkg.sv
// Package: shared constants and types of the context table loader.
// Assumes the fixed 51-word table layout; word indices are counted from the
// table base in 16-bit steps.
package ldr_pkg;

    localparam int LDR_WORD_W      = 16;
    localparam int LDR_BASE_W      = 24;
    localparam int LDR_ACC_W       = 8;
    localparam int LDR_MSW_W       = 4;
    localparam int LDR_TABLE_WORDS = 51;
    localparam int LDR_IDX_W       = $clog2(LDR_TABLE_WORDS);

    // word indices inside the table (behaviour depends on these positions)
    localparam int W_MSW          = 3;
    localparam int W_SINGLE_FIRST = 11;
    localparam int W_SINGLE_LAST  = 26;
    localparam int W_TR           = 11;
    localparam int W_FLAGS        = 12;
    localparam int W_IP           = 13;
    localparam int W_LDT          = 14;
    localparam int W_SEL_ES       = 18;   // selectors run DS..ES upwards
    localparam int W_GPR_FIRST    = 19;
    localparam int W_SEG_DESC     = 27;
    localparam int W_SYS_DESC     = 39;
    localparam int ENTRY_WORDS    = 3;

    localparam int SEG_COUNT = 4;   // ES, CS, SS, DS
    localparam int SYS_COUNT = 4;   // GDT, LDT cache, IDT, TSS cache
    localparam int GPR_COUNT = 8;   // DI, SI, BP, SP, BX, DX, CX, AX
    localparam int SEG_CS    = 1;
    localparam int SYS_GDT   = 0;
    localparam int SYS_LDTC  = 1;
    localparam int SYS_IDT   = 2;
    localparam int SYS_TSSC  = 3;

    typedef enum logic [1:0] {
        LDR_IDLE   = 2'd0,
        LDR_FETCH  = 2'd1,
        LDR_COMMIT = 2'd2
    } ldr_state_e;

    typedef struct packed {
        logic [LDR_BASE_W-1:0] base;
        logic [LDR_ACC_W-1:0]  acc;
        logic [LDR_WORD_W-1:0] lim;
    } desc_t;

    typedef struct packed {
        logic [LDR_BASE_W-1:0] base;
        logic [LDR_WORD_W-1:0] lim;
    } tbl_t;

    typedef struct packed {
        logic [LDR_MSW_W-1:0]                  msw;
        logic [LDR_WORD_W-1:0]                 tr;
        logic [LDR_WORD_W-1:0]                 flags;
        logic [LDR_WORD_W-1:0]                 ip;
        logic [LDR_WORD_W-1:0]                 ldt;
        logic [SEG_COUNT-1:0][LDR_WORD_W-1:0]  sel;
        logic [GPR_COUNT-1:0][LDR_WORD_W-1:0]  gpr;
        desc_t [SEG_COUNT-1:0]                 seg;
        tbl_t                                  gdt;
        tbl_t                                  idt;
        desc_t                                 ldtc;
        desc_t                                 tssc;
    } cpu_ctx_t;

endpackage

// File: rtl/ldr_seq.sv
// Module: read sequencer. Walks the table one word at a time from a fixed
// base, holds each address until acknowledged, then spends one cycle in a
// commit state. Assumes a single outstanding read; triggers are honoured
// only in the idle state.
module ldr_seq
    import ldr_pkg::*;
#(
    parameter int                ADDR_W     = 24,
    parameter logic [ADDR_W-1:0] TABLE_BASE = 24'h000800,
    parameter int                WORDS      = LDR_TABLE_WORDS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 mem_ready_i,
    output logic                 mem_req_o,
    output logic [ADDR_W-1:0]    mem_addr_o,
    output logic                 take_o,
    output logic [LDR_IDX_W-1:0] idx_o,
    output logic                 commit_o,
    output logic                 busy_o,
    output logic                 done_o
);

    localparam logic [LDR_IDX_W-1:0] LAST_IDX = LDR_IDX_W'(WORDS - 1);

    ldr_state_e           state_q;
    logic [LDR_IDX_W-1:0] idx_q;
    logic                 done_q;

    // state walk: idle -> fetch every word -> one commit cycle -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LDR_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                LDR_IDLE: begin
                    if (start_i) begin
                        state_q <= LDR_FETCH;
                        idx_q   <= '0;
                        done_q  <= 1'b0;
                    end
                end
                LDR_FETCH: begin
                    if (mem_ready_i) begin
                        if (idx_q == LAST_IDX) begin
                            state_q <= LDR_COMMIT;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                LDR_COMMIT: begin
                    state_q <= LDR_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= LDR_IDLE;
            endcase
        end
    end

    // memory side: word address is the base plus twice the word index
    assign mem_req_o  = (state_q == LDR_FETCH);
    assign mem_addr_o = TABLE_BASE + ADDR_W'({idx_q, 1'b0});

    // capture side and status
    assign take_o   = mem_req_o && mem_ready_i;
    assign idx_o    = idx_q;
    assign commit_o = (state_q == LDR_COMMIT);
    assign busy_o   = (state_q != LDR_IDLE);
    assign done_o   = done_q;

endmodule

// File: rtl/ldr_capture.sv
// Module: shadow capture. Sorts each accepted word into a shadow copy of the
// processor context according to its index. Dead words and unused bytes are
// never stored. Assumes take_i is high for exactly one cycle per word.
module ldr_capture
    import ldr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take_i,
    input  logic [LDR_IDX_W-1:0]  idx_i,
    input  logic [LDR_WORD_W-1:0] word_i,
    output cpu_ctx_t              shadow_o
);

    localparam logic [LDR_IDX_W-1:0] MSW_IDX = LDR_IDX_W'(W_MSW);

    logic [LDR_MSW_W-1:0]  msw_q;
    logic [LDR_WORD_W-1:0] single_q [W_SINGLE_FIRST:W_SINGLE_LAST];
    desc_t                 seg_q    [SEG_COUNT];
    tbl_t                  tbl_q    [SYS_COUNT];
    logic [LDR_ACC_W-1:0]  sacc_q   [2];

    // status word: keep only the low mode bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msw_q <= '0;
        end else if (take_i && idx_i == MSW_IDX) begin
            msw_q <= word_i[LDR_MSW_W-1:0];
        end
    end

    // one-word slots: a flop per slot, selected by its own index
    for (genvar s = W_SINGLE_FIRST; s <= W_SINGLE_LAST; s++) begin : g_single
        localparam logic [LDR_IDX_W-1:0] MY_IDX = LDR_IDX_W'(s);
        // capture the word whose index matches this slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                single_q[s] <= '0;
            end else if (take_i && idx_i == MY_IDX) begin
                single_q[s] <= word_i;
            end
        end
    end

    // segment caches: three words each, access byte kept
    for (genvar e = 0; e < SEG_COUNT; e++) begin : g_seg
        localparam logic [LDR_IDX_W-1:0] W0 = LDR_IDX_W'(W_SEG_DESC + ENTRY_WORDS * e);
        // fill base, access and limit of this cache from its three words
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[e] <= '0;
            end else if (take_i) begin
                if (idx_i == W0) begin
                    seg_q[e].base[15:0] <= word_i;
                end
                if (idx_i == W0 + 1'b1) begin
                    seg_q[e].base[23:16] <= word_i[7:0];
                    seg_q[e].acc         <= word_i[15:8];
                end
                if (idx_i == W0 + 2'd2) begin
                    seg_q[e].lim <= word_i;
                end
            end
        end
    end

    // system tables: base and limit always, access byte only for caches
    for (genvar t = 0; t < SYS_COUNT; t++) begin : g_sys
        localparam logic [LDR_IDX_W-1:0] W0 = LDR_IDX_W'(W_SYS_DESC + ENTRY_WORDS * t);
        // fill base and limit of this table register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl_q[t] <= '0;
            end else if (take_i) begin
                if (idx_i == W0) begin
                    tbl_q[t].base[15:0] <= word_i;
                end
                if (idx_i == W0 + 1'b1) begin
                    tbl_q[t].base[23:16] <= word_i[7:0];
                end
                if (idx_i == W0 + 2'd2) begin
                    tbl_q[t].lim <= word_i;
                end
            end
        end
        if (t == SYS_LDTC || t == SYS_TSSC) begin : g_acc
            // caches of the local table and task state keep their access byte
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sacc_q[t/2] <= '0;
                end else if (take_i && idx_i == W0 + 1'b1) begin
                    sacc_q[t/2] <= word_i[15:8];
                end
            end
        end
    end

    // assemble the shadow context from the stored pieces
    always_comb begin
        shadow_o       = '0;
        shadow_o.msw   = msw_q;
        shadow_o.tr    = single_q[W_TR];
        shadow_o.flags = single_q[W_FLAGS];
        shadow_o.ip    = single_q[W_IP];
        shadow_o.ldt   = single_q[W_LDT];
        for (int e = 0; e < SEG_COUNT; e++) begin
            shadow_o.sel[e] = single_q[W_SEL_ES - e];
            shadow_o.seg[e] = seg_q[e];
        end
        for (int g = 0; g < GPR_COUNT; g++) begin
            shadow_o.gpr[g] = single_q[W_GPR_FIRST + g];
        end
        shadow_o.gdt       = tbl_q[SYS_GDT];
        shadow_o.idt       = tbl_q[SYS_IDT];
        shadow_o.ldtc.base = tbl_q[SYS_LDTC].base;
        shadow_o.ldtc.lim  = tbl_q[SYS_LDTC].lim;
        shadow_o.ldtc.acc  = sacc_q[SYS_LDTC/2];
        shadow_o.tssc.base = tbl_q[SYS_TSSC].base;
        shadow_o.tssc.lim  = tbl_q[SYS_TSSC].lim;
        shadow_o.tssc.acc  = sacc_q[SYS_TSSC/2];
    end

endmodule

// File: rtl/ldr_bank.sv
// Module: architectural bank. Holds the visible context and moves the whole
// shadow across in one edge on commit; also registers the fetch address
// formed from the code segment cache base and the instruction pointer.
module ldr_bank
    import ldr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit_i,
    input  cpu_ctx_t              shadow_i,
    output cpu_ctx_t              ctx_o,
    output logic [LDR_BASE_W-1:0] fetch_o
);

    cpu_ctx_t              ctx_q;
    logic [LDR_BASE_W-1:0] fetch_q;

    // commit the whole shadow at once; hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q   <= '0;
            fetch_q <= '0;
        end else if (commit_i) begin
            ctx_q   <= shadow_i;
            fetch_q <= shadow_i.seg[SEG_CS].base + LDR_BASE_W'(shadow_i.ip);
        end
    end

    assign ctx_o   = ctx_q;
    assign fetch_o = fetch_q;

endmodule

// File: rtl/ctx_table_loader.sv
// Module: top of the context table loader. Ties the sequencer, the shadow
// capture and the architectural bank together and fans the context out.
// Assumes the memory returns data in the same cycle it raises ready.
module ctx_table_loader
    import ldr_pkg::*;
#(
    parameter int                ADDR_W     = 24,
    parameter logic [ADDR_W-1:0] TABLE_BASE = 24'h000800
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start_i,
    output logic                                 mem_req_o,
    output logic [ADDR_W-1:0]                    mem_addr_o,
    input  logic [LDR_WORD_W-1:0]                mem_rdata_i,
    input  logic                                 mem_ready_i,
    output logic                                 busy_o,
    output logic                                 commit_o,
    output logic                                 done_o,
    output logic [LDR_MSW_W-1:0]                 msw_o,
    output logic [LDR_WORD_W-1:0]                task_sel_o,
    output logic [LDR_WORD_W-1:0]                flags_o,
    output logic [LDR_WORD_W-1:0]                ip_o,
    output logic [LDR_WORD_W-1:0]                ldt_sel_o,
    output logic [SEG_COUNT-1:0][LDR_WORD_W-1:0] seg_sel_o,
    output logic [GPR_COUNT-1:0][LDR_WORD_W-1:0] gpr_o,
    output logic [SEG_COUNT-1:0][LDR_BASE_W-1:0] seg_base_o,
    output logic [SEG_COUNT-1:0][LDR_ACC_W-1:0]  seg_acc_o,
    output logic [SEG_COUNT-1:0][LDR_WORD_W-1:0] seg_lim_o,
    output logic [LDR_BASE_W-1:0]                gdt_base_o,
    output logic [LDR_WORD_W-1:0]                gdt_lim_o,
    output logic [LDR_BASE_W-1:0]                idt_base_o,
    output logic [LDR_WORD_W-1:0]                idt_lim_o,
    output logic [LDR_BASE_W-1:0]                ldtc_base_o,
    output logic [LDR_ACC_W-1:0]                 ldtc_acc_o,
    output logic [LDR_WORD_W-1:0]                ldtc_lim_o,
    output logic [LDR_BASE_W-1:0]                tssc_base_o,
    output logic [LDR_ACC_W-1:0]                 tssc_acc_o,
    output logic [LDR_WORD_W-1:0]                tssc_lim_o,
    output logic [LDR_BASE_W-1:0]                fetch_addr_o
);

    logic                 take;
    logic [LDR_IDX_W-1:0] idx;
    cpu_ctx_t             shadow;
    cpu_ctx_t             ctx;

    ldr_seq #(
        .ADDR_W     (ADDR_W),
        .TABLE_BASE (TABLE_BASE),
        .WORDS      (LDR_TABLE_WORDS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mem_ready_i (mem_ready_i),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .take_o      (take),
        .idx_o       (idx),
        .commit_o    (commit_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    ldr_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (take),
        .idx_i    (idx),
        .word_i   (mem_rdata_i),
        .shadow_o (shadow)
    );

    ldr_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit_o),
        .shadow_i (shadow),
        .ctx_o    (ctx),
        .fetch_o  (fetch_addr_o)
    );

    // fan the committed context out to the ports
    assign msw_o       = ctx.msw;
    assign task_sel_o  = ctx.tr;
    assign flags_o     = ctx.flags;
    assign ip_o        = ctx.ip;
    assign ldt_sel_o   = ctx.ldt;
    assign seg_sel_o   = ctx.sel;
    assign gpr_o       = ctx.gpr;
    assign gdt_base_o  = ctx.gdt.base;
    assign gdt_lim_o   = ctx.gdt.lim;
    assign idt_base_o  = ctx.idt.base;
    assign idt_lim_o   = ctx.idt.lim;
    assign ldtc_base_o = ctx.ldtc.base;
    assign ldtc_acc_o  = ctx.ldtc.acc;
    assign ldtc_lim_o  = ctx.ldtc.lim;
    assign tssc_base_o = ctx.tssc.base;
    assign tssc_acc_o  = ctx.tssc.acc;
    assign tssc_lim_o  = ctx.tssc.lim;

    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_segout
        assign seg_base_o[g] = ctx.seg[g].base;
        assign seg_acc_o[g]  = ctx.seg[g].acc;
        assign seg_lim_o[g]  = ctx.seg[g].lim;
    end

endmodule

// File: rtl/ldr_chk.sv
// Module: protocol checker for the context table loader, attached by bind.
// Assumes the default table length; all properties are reset-qualified.
module ldr_chk
    import ldr_pkg::*;
#(
    parameter int                ADDR_W     = 24,
    parameter logic [ADDR_W-1:0] TABLE_BASE = 24'h000800,
    parameter int                WORDS      = LDR_TABLE_WORDS
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 start_i,
    input logic                                 mem_req_o,
    input logic [ADDR_W-1:0]                    mem_addr_o,
    input logic                                 mem_ready_i,
    input logic                                 busy_o,
    input logic                                 commit_o,
    input logic                                 done_o,
    input logic [LDR_WORD_W-1:0]                ip_o,
    input logic [LDR_MSW_W-1:0]                 msw_o,
    input logic [GPR_COUNT-1:0][LDR_WORD_W-1:0] gpr_o,
    input logic [LDR_BASE_W-1:0]                fetch_addr_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = TABLE_BASE + ADDR_W'(2 * (WORDS - 1));

    // R2: requests stay inside the table on even addresses
    p_addr_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o >= TABLE_BASE && mem_addr_o <= LAST_ADDR && !mem_addr_o[0]));

    // R2: a load always begins at the table base
    p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o) |-> mem_addr_o == TABLE_BASE);

    // R2: an unacknowledged request is held unchanged
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R3: extra triggers never disturb the address walk
    p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mem_req_o && !(mem_ready_i && mem_addr_o == LAST_ADDR))
        |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + ($past(mem_ready_i) ? ADDR_W'(2) : ADDR_W'(0))));

    // R4: the last acknowledged word leads straight into commit
    p_commit_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ready_i && mem_addr_o == LAST_ADDR) |=> (commit_o && !mem_req_o));

    // R4: commit is a single pulse followed by done and idle
    p_commit_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (!commit_o && done_o && !busy_o));

    // R4: outputs move only at the end of a commit cycle
    p_hold_regs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_o |=> ($stable(ip_o) && $stable(msw_o) && $stable(gpr_o) && $stable(fetch_addr_o)));

endmodule

bind ctx_table_loader ldr_chk #(
    .ADDR_W     (ADDR_W),
    .TABLE_BASE (TABLE_BASE),
    .WORDS      (ldr_pkg::LDR_TABLE_WORDS)
) u_ldr_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_ready_i  (mem_ready_i),
    .busy_o       (busy_o),
    .commit_o     (commit_o),
    .done_o       (done_o),
    .ip_o         (ip_o),
    .msw_o        (msw_o),
    .gpr_o        (gpr_o),
    .fetch_addr_o (fetch_addr_o)
);

// File: tb/ctx_table_loader_tb.sv
// Bench: behavioural reference model of the loader, stepped on each rising
// edge and compared with the design on each falling edge.
module ctx_table_loader_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ready = 1'b0;
    always #2 clk = ~clk;

    logic                    mem_req, busy, commit, done;
    logic [23:0]             mem_addr;
    logic [15:0]             rdata;
    logic [3:0]              msw;
    logic [15:0]             tr, flags, ip, ldt;
    logic [3:0][15:0]        sel;
    logic [7:0][15:0]        gpr;
    logic [3:0][23:0]        sbase;
    logic [3:0][7:0]         sacc;
    logic [3:0][15:0]        slim;
    logic [23:0]             gdt_b, idt_b, ldtc_b, tssc_b, fetch;
    logic [15:0]             gdt_l, idt_l, ldtc_l, tssc_l;
    logic [7:0]              ldtc_a, tssc_a;

    ctx_table_loader dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(rdata), .mem_ready_i(ready),
        .busy_o(busy), .commit_o(commit), .done_o(done),
        .msw_o(msw), .task_sel_o(tr), .flags_o(flags), .ip_o(ip), .ldt_sel_o(ldt),
        .seg_sel_o(sel), .gpr_o(gpr), .seg_base_o(sbase), .seg_acc_o(sacc), .seg_lim_o(slim),
        .gdt_base_o(gdt_b), .gdt_lim_o(gdt_l), .idt_base_o(idt_b), .idt_lim_o(idt_l),
        .ldtc_base_o(ldtc_b), .ldtc_acc_o(ldtc_a), .ldtc_lim_o(ldtc_l),
        .tssc_base_o(tssc_b), .tssc_acc_o(tssc_a), .tssc_lim_o(tssc_l),
        .fetch_addr_o(fetch)
    );

    // table memory seen by the design
    logic [15:0] img [0:50];
    logic [23:0] rel;
    assign rel   = mem_addr - 24'h000800;
    assign rdata = (rel < 24'd102) ? img[rel[6:1]] : 16'hDEAD;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    int wait_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [15:0] w(input int a);
        return img[(a - 'h800) / 2];
    endfunction

    // reference state
    bit m_busy, m_commit, m_done;
    int m_idx;
    logic [3:0]       e_msw;
    logic [15:0]      e_tr, e_flags, e_ip, e_ldt;
    logic [3:0][15:0] e_sel;
    logic [7:0][15:0] e_gpr;
    logic [3:0][23:0] e_sbase;
    logic [3:0][7:0]  e_sacc;
    logic [3:0][15:0] e_slim;
    logic [23:0]      e_gdt_b, e_idt_b, e_ldtc_b, e_tssc_b, e_fetch;
    logic [15:0]      e_gdt_l, e_idt_l, e_ldtc_l, e_tssc_l;
    logic [7:0]       e_ldtc_a, e_tssc_a;

    task automatic clear_expected();
        e_msw = '0; e_tr = '0; e_flags = '0; e_ip = '0; e_ldt = '0;
        e_sel = '0; e_gpr = '0; e_sbase = '0; e_sacc = '0; e_slim = '0;
        e_gdt_b = '0; e_idt_b = '0; e_ldtc_b = '0; e_tssc_b = '0; e_fetch = '0;
        e_gdt_l = '0; e_idt_l = '0; e_ldtc_l = '0; e_tssc_l = '0;
        e_ldtc_a = '0; e_tssc_a = '0;
    endtask

    // decode the table by byte address, as the requirements state it
    task automatic apply_expected();
        logic [15:0] t, m;
        t = w('h806); e_msw = t[3:0];
        e_tr = w('h816); e_flags = w('h818); e_ip = w('h81A); e_ldt = w('h81C);
        for (int k = 0; k < 4; k++) e_sel[k] = w('h824 - 2 * k);
        for (int k = 0; k < 8; k++) e_gpr[k] = w('h826 + 2 * k);
        for (int k = 0; k < 4; k++) begin
            m = w('h838 + 6 * k);
            e_sbase[k] = {m[7:0], w('h836 + 6 * k)};
            e_sacc[k]  = m[15:8];
            e_slim[k]  = w('h83A + 6 * k);
        end
        m = w('h850); e_gdt_b  = {m[7:0], w('h84E)}; e_gdt_l  = w('h852);
        m = w('h856); e_ldtc_b = {m[7:0], w('h854)}; e_ldtc_a = m[15:8]; e_ldtc_l = w('h858);
        m = w('h85C); e_idt_b  = {m[7:0], w('h85A)}; e_idt_l  = w('h85E);
        m = w('h862); e_tssc_b = {m[7:0], w('h860)}; e_tssc_a = m[15:8]; e_tssc_l = w('h864);
        e_fetch = 24'((32'(e_sbase[1]) + 32'(e_ip)) & 32'hFFFFFF);
    endtask

    // reference model steps on the rising edge from bench-driven inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_commit = 0; m_done = 0; m_idx = 0;
            clear_expected();
        end else if (m_commit) begin
            apply_expected();
            m_done = 1; m_commit = 0; m_busy = 0;
        end else if (m_busy) begin
            if (ready) begin
                if (m_idx == 50) m_commit = 1;
                else m_idx++;
            end
        end else if (start) begin
            m_busy = 1; m_idx = 0; m_done = 0;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h at cycle %0d", (rst_n ? tag : "R1"), what, act, exp, cyc);
        end
    endtask

    // compare every output on the falling edge, then drive the acknowledge
    always @(negedge clk) begin
        chk("R2", "mem_req", 32'(mem_req), 32'(m_busy && !m_commit));
        if (m_busy && !m_commit) chk("R2", "mem_addr", 32'(mem_addr), 32'h800 + 32'(2 * m_idx));
        chk("R4", "busy", 32'(busy), 32'(m_busy));
        chk("R4", "commit", 32'(commit), 32'(m_commit));
        chk("R4", "done", 32'(done), 32'(m_done));
        chk("R9", "msw", 32'(msw), 32'(e_msw));
        chk("R5", "task_sel", 32'(tr), 32'(e_tr));
        chk("R5", "flags", 32'(flags), 32'(e_flags));
        chk("R5", "ip", 32'(ip), 32'(e_ip));
        chk("R5", "ldt_sel", 32'(ldt), 32'(e_ldt));
        for (int k = 0; k < 4; k++) begin
            chk("R5", "seg_sel", 32'(sel[k]), 32'(e_sel[k]));
            chk("R7", "seg_base", 32'(sbase[k]), 32'(e_sbase[k]));
            chk("R7", "seg_acc", 32'(sacc[k]), 32'(e_sacc[k]));
            chk("R7", "seg_lim", 32'(slim[k]), 32'(e_slim[k]));
        end
        for (int k = 0; k < 8; k++) chk("R6", "gpr", 32'(gpr[k]), 32'(e_gpr[k]));
        chk("R8", "gdt_base", 32'(gdt_b), 32'(e_gdt_b));
        chk("R8", "gdt_lim", 32'(gdt_l), 32'(e_gdt_l));
        chk("R8", "idt_base", 32'(idt_b), 32'(e_idt_b));
        chk("R8", "idt_lim", 32'(idt_l), 32'(e_idt_l));
        chk("R7", "ldtc", {ldtc_b, ldtc_a}, {e_ldtc_b, e_ldtc_a});
        chk("R7", "ldtc_lim", 32'(ldtc_l), 32'(e_ldtc_l));
        chk("R7", "tssc", {tssc_b, tssc_a}, {e_tssc_b, e_tssc_a});
        chk("R7", "tssc_lim", 32'(tssc_l), 32'(e_tssc_l));
        chk("R10", "fetch", 32'(fetch), 32'(e_fetch));
        lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ready = mem_req && (wait_mode == 0 || lfsr[0]);
    end

    task automatic fill(input int seed);
        for (int i = 0; i < 51; i++) img[i] = 16'((i * 32'h3B1 + seed * 32'h9E37) ^ (seed << 3));
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // trigger a load, optionally poke extra triggers during it, wait for done
    task automatic run_load(input int extra);
        pulse_start();
        for (int p = 0; p < extra; p++) begin
            repeat (7 + 5 * p) @(negedge clk);
            pulse_start();   // R3: ignored while busy
        end
        for (int t = 0; t < 3000 && !(done && !busy); t++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    logic [7:0][15:0] snap_gpr;
    logic [23:0]      snap_fetch;
    logic [3:0]       snap_msw;
    logic [23:0]      snap_gdt, snap_idt;

    initial begin
        fill(1);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet state after reset
        chk("R1", "idle_fetch", 32'(fetch), 32'h0);
        chk("R1", "idle_req", 32'(mem_req), 32'h0);

        // plain load, memory always ready
        wait_mode = 0;
        run_load(0);
        chk("R4", "done_after_load", 32'(done), 32'h1);

        // stalled memory, extra triggers, noisy spare bits
        wait_mode = 1;
        fill(7);
        img[3]  = 16'hFFF5;        // R9: only low nibble kept
        img[40] = 16'hAB12;        // R8: GDT spare byte
        img[46] = 16'hCD34;        // R8: IDT spare byte
        run_load(3);
        chk("R9", "msw_low_only", 32'(msw), 32'h5);
        chk("R8", "gdt_hi", 32'(gdt_b[23:16]), 32'h12);
        chk("R8", "idt_hi", 32'(idt_b[23:16]), 32'h34);

        // R11 / R8 / R9: change only ignored bytes and reload
        snap_gpr = gpr; snap_fetch = fetch; snap_msw = msw; snap_gdt = gdt_b; snap_idt = idt_b;
        for (int i = 0; i < 3; i++) img[i] = 16'(16'h5A5A + i);
        for (int i = 4; i < 11; i++) img[i] = 16'(16'hC3C3 - i);
        img[3]  = {12'h9A3, img[3][3:0]};
        img[40] = {8'h77, img[40][7:0]};
        img[46] = {8'h11, img[46][7:0]};
        run_load(0);
        for (int k = 0; k < 8; k++) chk("R11", "gpr_unchanged", 32'(gpr[k]), 32'(snap_gpr[k]));
        chk("R11", "fetch_unchanged", 32'(fetch), 32'(snap_fetch));
        chk("R9", "msw_unchanged", 32'(msw), 32'(snap_msw));
        chk("R8", "gdt_unchanged", 32'(gdt_b), 32'(snap_gdt));
        chk("R8", "idt_unchanged", 32'(idt_b), 32'(snap_idt));

        // R10: CS base near the top wraps; CS selector is irrelevant
        fill(23);
        img[30] = 16'hFFF0;        // CS cache base low
        img[31] = 16'h93FF;        // access 0x93, base high 0xFF
        img[13] = 16'h0030;        // instruction pointer
        img[17] = 16'h1234;        // CS selector
        wait_mode = 0;
        run_load(1);
        chk("R10", "fetch_wrap", 32'(fetch), 32'h000020);
        chk("R5", "cs_selector", 32'(sel[1]), 32'h1234);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule